// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the memory side of a load-multiple or store-multiple operation. On a start pulse it captures a base address, a 16-bit register mask, one of four addressing modes, a direction bit (load or store) and a base-update flag. It then emits one word request per set bit of the mask, one per cycle, each carrying a word address and the register number that the transfer belongs to. When the last request has been accepted, it presents the updated base value for the register file to write back.

The sizing of the address window depends on how many bits are set in the mask, so the starting address is known in the cycle after start, before the first request. The lowest-numbered register always goes to the lowest address, whichever mode is used. The four modes also cover the usual stack disciplines. A descending stack whose pointer names the last used slot pushes with decrement-before and pops with increment-after. An ascending stack of the same kind pushes with increment-before. An ascending stack whose pointer names the next free slot pushes with increment-after. The register file and the memory lie outside this block.

Top module: `blkx_seq`

## Requirements
- R1: The first request address depends on `mode`, with `count` the number of set bits of `reg_list`. Mode 0 (increment after) uses base. Mode 1 (increment before) uses base+4. Mode 2 (decrement after) uses base-4*count+4. Mode 3 (decrement before) uses base-4*count.
- R2: Exactly `count` requests are accepted. Their `mem_reg` values rise strictly, from the lowest set bit of the mask to the highest, and each accepted request's address is 4 above the previous one.
- R3: In the cycle `done` is high, `wb_value` holds base+4*count for modes 0 and 1, or base-4*count for modes 2 and 3, computed from the full base value. `wb_valid` equals `done` AND the captured writeback flag.
- R4: An all-zero mask gives `done` in the cycle after start. No request is raised, and `wb_value` equals the unchanged base.
- R5: While `mem_req` is high and `ready` is low, the request holds: `mem_req`, `mem_addr` and `mem_reg` stay unchanged in the next cycle.
- R6: A `start` pulse while `busy` is high has no effect on the running sequence. Changes of `base`, `reg_list` and `mode` after the start cycle also have no effect.
- R7: `mem_we` is high exactly for store operations (`is_load`=0). The two low bits of every `mem_addr` are zero, because the low two bits of the base are dropped when forming addresses.
- R8: After reset `busy`, `done` and `mem_req` are low. `busy` and `mem_req` rise in the cycle after an accepted start. `done` is a one-cycle pulse in the cycle after the last accepted request. With no stalls, an N-register operation spans N+1 cycles from start to `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken when not busy) |
| base | input | 32 | Base register value |
| reg_list | input | 16 | Register mask, bit i selects register i |
| mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| is_load | input | 1 | 1 load, 0 store |
| wb_en | input | 1 | Base writeback requested |
| ready | input | 1 | Memory accepts the current request |
| busy | output | 1 | Requests are being issued |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned request address |
| mem_reg | output | 4 | Register number of this request |
| wb_valid | output | 1 | Write `wb_value` into the base register |
| wb_value | output | 32 | Updated base value |

## Verification
The bench replays the worked sequence for each mode, using three registers and the bases 0x10 and 0x24. A design that mixed up the before and after offsets would start one word off. A design that walked downward in the decrement modes would reverse the register order. A full 16-register store from a misaligned base, under a ready pattern with frequent stalls, would expose a design that advanced during a stall or leaked the base's low bits into the addresses. An empty mask, a sparse mask whose window wraps below address zero, and a start pulse landing mid-sequence would expose a design that issued a spurious request, miscounted the span, or restarted.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        XM_INC_AFTER  = 2'd0,
        XM_INC_BEFORE = 2'd1,
        XM_DEC_AFTER  = 2'd2,
        XM_DEC_BEFORE = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic store;
        logic wb;
    } op_flags_t;

    function automatic int unsigned count_ones(logic [31:0] v);
        int unsigned n = 0;
        for (int i = 0; i < 32; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic is_down(xfer_mode_e m);
        return (m == XM_DEC_AFTER) || (m == XM_DEC_BEFORE);
    endfunction

endpackage

// File: rtl/blkx_pick.sv
module blkx_pick #(
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask,
    output logic [NREG-1:0] onehot,
    output logic [IDXW-1:0] idx,
    output logic            last
);
    // Isolate the lowest set bit; it is the next register to move.
    assign onehot = mask & (~mask + NREG'(1));
    assign last   = ((mask & (mask - NREG'(1))) == '0);

    always_comb begin
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (onehot[i]) idx = idx | IDXW'(i);
        end
    end
endmodule

// File: rtl/blkx_addr_calc.sv
module blkx_addr_calc
    import blkx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    localparam int CNTW  = $clog2(NREG + 1)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [NREG-1:0]   reg_list,
    input  xfer_mode_e        mode,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] new_base
);
    logic [CNTW-1:0]   cnt;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] raw;

    assign cnt  = CNTW'(count_ones(32'(reg_list)));
    assign span = ADDR_W'(cnt) * ADDR_W'(WORD_BYTES);

    always_comb begin
        unique case (mode)
            XM_INC_AFTER:  raw = base;
            XM_INC_BEFORE: raw = base + ADDR_W'(WORD_BYTES);
            XM_DEC_AFTER:  raw = base - span + ADDR_W'(WORD_BYTES);
            default:       raw = base - span;
        endcase
    end

    assign first_addr = raw & ~ADDR_W'(WORD_BYTES - 1);
    assign new_base   = is_down(mode) ? (base - span) : (base + span);
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
    import blkx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    localparam int IDXW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [NREG-1:0]   reg_list,
    input  logic [1:0]        mode,
    input  logic              is_load,
    input  logic              wb_en,
    input  logic              ready,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [IDXW-1:0]   mem_reg,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_value
);
    seq_state_e        state_q;
    logic [NREG-1:0]   mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] fin_q;
    op_flags_t         flags_q;

    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] new_base;
    logic [NREG-1:0]   pick_oh;
    logic [IDXW-1:0]   pick_idx;
    logic              pick_last;
    logic              accept;
    logic              fire;

    blkx_addr_calc #(.ADDR_W(ADDR_W), .NREG(NREG)) u_calc (
        .base       (base),
        .reg_list   (reg_list),
        .mode       (xfer_mode_e'(mode)),
        .first_addr (first_addr),
        .new_base   (new_base)
    );

    blkx_pick #(.NREG(NREG)) u_pick (
        .mask   (mask_q),
        .onehot (pick_oh),
        .idx    (pick_idx),
        .last   (pick_last)
    );

    assign accept = start && (state_q != ST_XFER);
    assign fire   = (state_q == ST_XFER) && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            addr_q  <= '0;
            fin_q   <= '0;
            flags_q <= '0;
        end else if (accept) begin
            mask_q        <= reg_list;
            addr_q        <= first_addr;
            fin_q         <= new_base;
            flags_q.store <= ~is_load;
            flags_q.wb    <= wb_en;
            state_q       <= (reg_list == '0) ? ST_FIN : ST_XFER;
        end else if (fire) begin
            mask_q <= mask_q & ~pick_oh;
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
            if (pick_last) state_q <= ST_FIN;
        end else if (state_q == ST_FIN) begin
            state_q <= ST_IDLE;
        end
    end

    assign busy     = (state_q == ST_XFER);
    assign mem_req  = busy;
    assign mem_we   = flags_q.store;
    assign mem_addr = addr_q;
    assign mem_reg  = pick_idx;
    assign done     = (state_q == ST_FIN);
    assign wb_valid = done && flags_q.wb;
    assign wb_value = fin_q;

    // R5: a stalled request holds its address and register
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req && !ready |=> mem_req && $stable(mem_addr) && $stable(mem_reg));

    // R2: consecutive accepted requests step by one word
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req && ready && !pick_last |=> mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES));

    // R2: register numbers strictly rise
    p_reg_order_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req && ready && !pick_last |=> mem_reg > $past(mem_reg));

    // R7: every request address is word aligned
    p_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R8: done only follows a final acceptance or an empty-list start
    p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_req && ready) || $past(start));

    // R6: a start while busy does not end the sequence early
    p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
        busy && start && !ready |=> busy);
endmodule

// File: tb/tb_blkx_seq.sv
module tb_blkx_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] base;
    logic [15:0] reg_list;
    logic [1:0]  mode;
    logic        is_load;
    logic        wb_en;
    logic        ready;
    logic        busy, done, mem_req, mem_we, wb_valid;
    logic [31:0] mem_addr, wb_value;
    logic [3:0]  mem_reg;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blkx_seq dut (
        .clk(clk), .rst(rst), .start(start), .base(base), .reg_list(reg_list),
        .mode(mode), .is_load(is_load), .wb_en(wb_en), .ready(ready),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_reg(mem_reg), .wb_valid(wb_valid),
        .wb_value(wb_value)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Runs one operation and checks it against values computed here.
    task automatic run_op(input logic [31:0] b, input logic [15:0] lst,
                          input logic [1:0] md, input logic ld, input logic wbe,
                          input logic [31:0] pat, input logic poke);
        logic [31:0] rec_addr [16];
        logic [3:0]  rec_reg  [16];
        logic [31:0] exp_first, exp_fin, stall_addr, got_wb;
        logic        got_wbv, seen_done, prev_stall, stall_ok, we_ok, al_ok;
        int n, got, stalls, c, k, cycles;
        n = $countones(lst);
        case (md)
            2'd0: exp_first = b;
            2'd1: exp_first = b + 4;
            2'd2: exp_first = b - 32'(4 * n) + 4;
            default: exp_first = b - 32'(4 * n);
        endcase
        exp_first = exp_first & ~32'h3;
        exp_fin = md[1] ? b - 32'(4 * n) : b + 32'(4 * n);

        @(negedge clk);
        base = b; reg_list = lst; mode = md; is_load = ld; wb_en = wbe; start = 1'b1;
        @(negedge clk);
        start = 1'b0; base = 32'hDEAD_BEE0; reg_list = 16'h5555; mode = ~md;
        got = 0; stalls = 0; c = 0; cycles = 0; seen_done = 0; prev_stall = 0;
        stall_ok = 1; we_ok = 1; al_ok = 1; got_wb = '0; got_wbv = 0; stall_addr = '0;
        chk(n == 0 ? !busy : busy, "R8", "busy after start", 32'(busy), 32'(n != 0));
        while (!seen_done && c < 200) begin
            ready = pat[c % 32];
            start = poke && (c == 1);
            if (poke && c == 1) begin reg_list = 16'h0001; base = 32'h0; end
            #1;
            if (prev_stall && !(mem_req && mem_addr == stall_addr)) stall_ok = 0;
            prev_stall = 0;
            if (done) begin
                seen_done = 1; got_wb = wb_value; got_wbv = wb_valid; cycles = c + 1;
            end else if (mem_req) begin
                if (mem_we != !ld) we_ok = 0;
                if (mem_addr[1:0] != 2'b00) al_ok = 0;
                if (ready) begin
                    if (got < 16) begin rec_addr[got] = mem_addr; rec_reg[got] = mem_reg; end
                    got++;
                end else begin
                    stalls++; prev_stall = 1; stall_addr = mem_addr;
                end
            end
            c++;
            @(negedge clk);
        end
        start = 1'b0; ready = 1'b1;
        chk(seen_done, "R8", "done seen", 32'(seen_done), 32'd1);
        chk(!done, "R8", "done one cycle", 32'(done), 32'd0);
        chk(got == n, "R2", "transfer count", 32'(got), 32'(n));
        chk(cycles == n + stalls + 1, "R8", "cycles to done", 32'(cycles), 32'(n + stalls + 1));
        chk(stall_ok, "R5", "stall hold", 32'(stall_ok), 32'd1);
        chk(we_ok && al_ok, "R7", "write flag and alignment", {30'd0, we_ok, al_ok}, 32'd3);
        chk(got_wb == exp_fin, "R3", "writeback value", got_wb, exp_fin);
        chk(got_wbv == wbe, "R3", "writeback valid", 32'(got_wbv), 32'(wbe));
        if (n > 0 && got == n) begin
            chk(rec_addr[0] == exp_first, "R1", "first address", rec_addr[0], exp_first);
            k = 0;
            for (int i = 0; i < 16; i++) begin
                if (lst[i]) begin
                    chk(rec_reg[k] == 4'(i), poke ? "R6" : "R2", "register order",
                        32'(rec_reg[k]), 32'(i));
                    chk(rec_addr[k] == exp_first + 32'(4 * k), "R2", "address step",
                        rec_addr[k], exp_first + 32'(4 * k));
                    k++;
                end
            end
        end
    endtask

    task automatic t_reset();
        #1;
        chk(!busy && !done && !mem_req, "R8", "reset state",
            {29'd0, busy, done, mem_req}, 32'd0);
    endtask

    task automatic t_modes();
        run_op(32'h10, 16'h000E, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0); // R1 inc after
        run_op(32'h10, 16'h000E, 2'd1, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0); // R1 inc before
        run_op(32'h24, 16'h000E, 2'd2, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0); // R1 dec after
        run_op(32'h24, 16'h000E, 2'd3, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0); // R1 dec before
    endtask

    task automatic t_full_store_stall();
        run_op(32'h0000_0103, 16'hFFFF, 2'd0, 1'b0, 1'b1, 32'hA5C3_6E91, 1'b0); // R5 R7
    endtask

    task automatic t_empty();
        run_op(32'h0000_4444, 16'h0000, 2'd3, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0); // R4
    endtask

    task automatic t_poke();
        run_op(32'h0000_0200, 16'h0F0F, 2'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1); // R6
    endtask

    task automatic t_sparse_wrap();
        run_op(32'h0, 16'h8001, 2'd3, 1'b1, 1'b0, 32'h3333_3333, 1'b0); // R1 R3 wrap
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; base = '0; reg_list = '0; mode = '0;
        is_load = 1'b1; wb_en = 1'b0; ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_modes();
        t_full_store_stall();
        t_empty();
        t_poke();
        t_sparse_wrap();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule